// File: doc/BRIEF.md
# Bus-Requesting Block Transfer Engine

This engine sits on the device side of a shared system bus. It copies a block of words from a small local buffer into memory. Software fills the buffer, writes a destination word address and a word count, and then issues a go command. The engine raises a bus request. It makes no memory access until the bus owner returns a grant. While it holds the grant it writes the block to consecutive word addresses, then withdraws its request and raises an interrupt that stays set until software clears it.

Two transfer modes are selected with the go command. Burst mode writes one word in every cycle in which the grant is present, so a held grant moves the whole block back to back. Cycle-stealing mode writes a word only in a granted cycle in which the bus is also observed idle. A go command issued while a transfer is running is ignored, and it sets a sticky error flag.

Top module: `dma_xfer_engine`

## Requirements
- R1: `mem_we` is high only in cycles where `bus_req` and `bus_gnt` are both high. `bus_req` rises in the cycle after the go write and stays high until the block is finished.
- R2: The first write goes to the programmed start address and carries buffer word 0. Each later write of the same block goes to the previous address plus one and carries the next buffer word.
- R3: In burst mode (go written with control bit 1 = 0), a write happens in every cycle where the grant is high, whatever the value of `bus_busy`.
- R4: In cycle-stealing mode (control bit 1 = 1), a write happens only in cycles where the grant is high and `bus_busy` is low.
- R5: `irq` is high in the cycle that follows the final write of the block.
- R6: `bus_req` is low in the cycle that follows the final write of the block.
- R7: `irq` stays high until a control write with bit 2 = 1. That write clears it in the following cycle.
- R8: A go write while a transfer is active has no effect on the running transfer. It sets status bit 2 (error), which stays set until a control write with bit 3 = 1.
- R9: A go command with a word count of zero makes no bus request and raises `irq` in the next cycle.
- R10: A count write greater than the buffer depth (16 by default) is stored as the depth and reads back as the depth.
- R11: Register map on `cfg_addr`: 0 is the start address, 1 is the word count, 2 is control on write (bit 0 go, bit 1 steal mode, bit 2 interrupt clear, bit 3 error clear) and status on read (bit 0 active, bit 1 irq, bit 2 error). After reset all registers read zero and `bus_req`, `irq` and `mem_we` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | RW | Register write data |
| cfg_rdata | output | RW | Register read data for `cfg_addr` |
| buf_we | input | 1 | Local buffer write strobe |
| buf_idx | input | IW | Local buffer word index |
| buf_wdata | input | DW | Local buffer write data |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus grant from the owner |
| bus_busy | input | 1 | Bus observed in use by another agent |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest situation to reach is a go command that lands in the middle of an active transfer. The transfer must keep its original address and word sequence, and the error flag must latch. To get there, the bench starts a burst with the grant held low. It rewrites the start address, issues a second go, and then lets the grant arrive with a gap in the middle. Every write is then compared against the first programmed address. The cycle-stealing case drives a busy pattern that opens idle windows at irregular cycles, so that each write can be matched to a specific idle cycle.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;
    typedef enum logic [1:0] {
        REG_ADDR  = 2'd0,
        REG_COUNT = 2'd1,
        REG_CTRL  = 2'd2,
        REG_SPARE = 2'd3
    } reg_sel_e;

    localparam int CTRL_GO      = 0;
    localparam int CTRL_STEAL   = 1;
    localparam int CTRL_IRQ_CLR = 2;
    localparam int CTRL_ERR_CLR = 3;

    localparam int STAT_ACTIVE  = 0;
    localparam int STAT_IRQ     = 1;
    localparam int STAT_ERR     = 2;
endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
    import dma_xfer_pkg::*;
#(
    parameter int AW    = 16,
    parameter int CW    = 5,
    parameter int DEPTH = 16,
    parameter int RW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_addr,
    input  logic [RW-1:0] cfg_wdata,
    output logic [RW-1:0] cfg_rdata,
    input  logic          active,
    input  logic          done,
    output logic [AW-1:0] start_addr,
    output logic [CW-1:0] word_cnt,
    output logic          go,
    output logic          go_steal,
    output logic          irq
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic [CW-1:0] cnt;
        logic          irq;
        logic          err;
    } cfg_state_t;

    cfg_state_t st_d, st_q;
    logic       ctrl_wr;

    always_comb begin
        st_d     = st_q;
        ctrl_wr  = cfg_we && (cfg_addr == REG_CTRL);
        go       = ctrl_wr && cfg_wdata[CTRL_GO];
        go_steal = cfg_wdata[CTRL_STEAL];
        if (cfg_we && cfg_addr == REG_ADDR) begin
            st_d.addr = cfg_wdata[AW-1:0];
        end
        if (cfg_we && cfg_addr == REG_COUNT) begin
            if (cfg_wdata > RW'(DEPTH)) begin
                st_d.cnt = CW'(DEPTH);
            end else begin
                st_d.cnt = cfg_wdata[CW-1:0];
            end
        end
        if (ctrl_wr && cfg_wdata[CTRL_IRQ_CLR]) begin
            st_d.irq = 1'b0;
        end
        if (ctrl_wr && cfg_wdata[CTRL_ERR_CLR]) begin
            st_d.err = 1'b0;
        end
        if (go && active) begin
            st_d.err = 1'b1;
        end
        if (done) begin
            st_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            REG_ADDR:  cfg_rdata[AW-1:0] = st_q.addr;
            REG_COUNT: cfg_rdata[CW-1:0] = st_q.cnt;
            REG_CTRL: begin
                cfg_rdata[STAT_ACTIVE] = active;
                cfg_rdata[STAT_IRQ]    = st_q.irq;
                cfg_rdata[STAT_ERR]    = st_q.err;
            end
            default:   cfg_rdata = '0;
        endcase
    end

    assign start_addr = st_q.addr;
    assign word_cnt   = st_q.cnt;
    assign irq        = st_q.irq;
endmodule

// File: rtl/dma_word_buf.sv
module dma_word_buf #(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    parameter int IW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] word_q [DEPTH];
    logic [DW-1:0] word_d [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
        always_comb begin
            word_d[gi] = word_q[gi];
            if (wr_en && wr_idx == IW'(gi)) begin
                word_d[gi] = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q[gi] <= '0;
            end else begin
                word_q[gi] <= word_d[gi];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (rd_idx == IW'(k)) begin
                rd_data = word_q[k];
            end
        end
    end
endmodule

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl #(
    parameter int AW = 16,
    parameter int CW = 5,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          go_steal,
    input  logic [AW-1:0] start_addr,
    input  logic [CW-1:0] word_cnt,
    input  logic          bus_gnt,
    input  logic          bus_busy,
    output logic          bus_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [IW-1:0] rd_idx,
    output logic          done,
    output logic          active,
    output logic          steal
);
    typedef struct packed {
        logic          active;
        logic          steal;
        logic [AW-1:0] addr;
        logic [CW-1:0] idx;
        logic [CW-1:0] left;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    logic        wr;

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        wr   = st_q.active && bus_gnt && (!st_q.steal || !bus_busy);
        if (!st_q.active && go) begin
            if (word_cnt == '0) begin
                done = 1'b1;
            end else begin
                st_d.active = 1'b1;
                st_d.steal  = go_steal;
                st_d.addr   = start_addr;
                st_d.idx    = '0;
                st_d.left   = word_cnt;
            end
        end
        if (wr) begin
            st_d.addr = st_q.addr + AW'(1);
            st_d.idx  = st_q.idx + CW'(1);
            st_d.left = st_q.left - CW'(1);
            if (st_q.left == CW'(1)) begin
                st_d.active = 1'b0;
                done        = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_req  = st_q.active;
    assign mem_we   = wr;
    assign mem_addr = st_q.addr;
    assign rd_idx   = st_q.idx[IW-1:0];
    assign active   = st_q.active;
    assign steal    = st_q.steal;
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine #(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    parameter int RW    = 32,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_addr,
    input  logic [RW-1:0] cfg_wdata,
    output logic [RW-1:0] cfg_rdata,
    input  logic          buf_we,
    input  logic [IW-1:0] buf_idx,
    input  logic [DW-1:0] buf_wdata,
    output logic          bus_req,
    input  logic          bus_gnt,
    input  logic          bus_busy,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          irq
);
    logic [AW-1:0] start_addr;
    logic [CW-1:0] word_cnt;
    logic          go;
    logic          go_steal;
    logic          done;
    logic          active;
    logic          xfer_steal;
    logic [IW-1:0] rd_idx;

    dma_cfg_regs #(.AW(AW), .CW(CW), .DEPTH(DEPTH), .RW(RW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .active     (active),
        .done       (done),
        .start_addr (start_addr),
        .word_cnt   (word_cnt),
        .go         (go),
        .go_steal   (go_steal),
        .irq        (irq)
    );

    dma_word_buf #(.DW(DW), .DEPTH(DEPTH), .IW(IW)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (buf_we),
        .wr_idx  (buf_idx),
        .wr_data (buf_wdata),
        .rd_idx  (rd_idx),
        .rd_data (mem_wdata)
    );

    dma_xfer_ctrl #(.AW(AW), .CW(CW), .IW(IW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .go_steal   (go_steal),
        .start_addr (start_addr),
        .word_cnt   (word_cnt),
        .bus_gnt    (bus_gnt),
        .bus_busy   (bus_busy),
        .bus_req    (bus_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .rd_idx     (rd_idx),
        .done       (done),
        .active     (active),
        .steal      (xfer_steal)
    );
endmodule

// File: rtl/dma_xfer_engine_chk.sv
module dma_xfer_engine_chk #(
    parameter int AW = 16,
    parameter int RW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_req,
    input logic          bus_gnt,
    input logic          bus_busy,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          irq,
    input logic          steal,
    input logic          cfg_we,
    input logic [1:0]    cfg_addr,
    input logic [RW-1:0] cfg_wdata
);
    p_no_write_without_grant_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (bus_gnt && bus_req));

    p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mem_we) && mem_we && $past(bus_req) && bus_req)
            |-> (mem_addr == $past(mem_addr) + AW'(1)));

    p_steal_idle_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && steal) |-> !bus_busy);

    p_irq_at_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req) |-> irq);

    p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(cfg_we && cfg_addr == 2'd2 && cfg_wdata[2])) |=> irq);
endmodule

bind dma_xfer_engine dma_xfer_engine_chk #(.AW(AW), .RW(RW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_gnt   (bus_gnt),
    .bus_busy  (bus_busy),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .irq       (irq),
    .steal     (xfer_steal),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata)
);

// File: tb/dma_xfer_engine_tb.sv
`timescale 1ns/1ps
module dma_xfer_engine_tb;
    localparam int AW = 16, DW = 32, DEPTH = 16, RW = 32, IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_addr = '0;
    logic [RW-1:0] cfg_wdata = '0;
    logic [RW-1:0] cfg_rdata;
    logic          buf_we = 1'b0;
    logic [IW-1:0] buf_idx = '0;
    logic [DW-1:0] buf_wdata = '0;
    logic          bus_req;
    logic          bus_gnt = 1'b0;
    logic          bus_busy = 1'b0;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          irq;

    int n_checks = 0;
    int n_fail = 0;
    logic [DW-1:0] exp_buf [DEPTH];

    always #2.5 clk = ~clk;

    dma_xfer_engine #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .RW(RW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .buf_we(buf_we),
        .buf_idx(buf_idx), .buf_wdata(buf_wdata), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .bus_busy(bus_busy), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Returns at the negedge one cycle after the write edge.
    task automatic cfg_write(input logic [1:0] a, input logic [RW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    task automatic read_reg(input logic [1:0] a, output logic [RW-1:0] v);
        cfg_addr = a;
        #1;
        v = cfg_rdata;
    endtask

    // Cycle-by-cycle run: writes predicted from grant/busy patterns.
    task automatic xfer_run(input logic [AW-1:0] base, input int n, input bit stl,
                            input logic [31:0] gnt_pat, input logic [31:0] busy_pat,
                            input string tag);
        int left = n;
        int idx = 0;
        for (int i = 0; i < 32 && left > 0; i++) begin
            bus_gnt = gnt_pat[i];
            bus_busy = busy_pat[i];
            #1;
            begin
                bit exp_we = bus_gnt && (!stl || !bus_busy);
                check(bus_req == 1'b1, {tag, " R1 request held"}, 64'(bus_req), 64'd1);
                check(mem_we == exp_we, {tag, stl ? " R4 steal strobe" : " R3 burst strobe"},
                      64'(mem_we), 64'(exp_we));
                if (exp_we && mem_we) begin
                    check(mem_addr == base + AW'(idx), {tag, " R2 address"},
                          64'(mem_addr), 64'(base + AW'(idx)));
                    check(mem_wdata == exp_buf[idx], {tag, " R2 data"},
                          64'(mem_wdata), 64'(exp_buf[idx]));
                end
                if (exp_we) begin
                    left--; idx++;
                end
            end
            @(negedge clk);
        end
        bus_gnt = 1'b0; bus_busy = 1'b0;
        #1;
        check(bus_req == 1'b0, {tag, " R6 request dropped"}, 64'(bus_req), 64'd0);
        check(irq == 1'b1, {tag, " R5 irq raised"}, 64'(irq), 64'd1);
        check(mem_we == 1'b0, {tag, " R1 no write after block"}, 64'(mem_we), 64'd0);
    endtask

    task automatic clear_irq(input string tag);
        logic [RW-1:0] v;
        repeat (3) @(negedge clk);
        check(irq == 1'b1, {tag, " R7 irq held"}, 64'(irq), 64'd1);
        cfg_write(2'd2, 32'h4);
        #1;
        check(irq == 1'b0, {tag, " R7 irq cleared"}, 64'(irq), 64'd0);
        read_reg(2'd2, v);
        check(v[1] == 1'b0, {tag, " R11 status irq bit"}, 64'(v), 64'd0);
    endtask

    task automatic t_reset;
        logic [RW-1:0] v;
        check(bus_req == 1'b0 && irq == 1'b0 && mem_we == 1'b0, "R11 reset outputs",
              64'({bus_req, irq, mem_we}), 64'd0);
        for (int r = 0; r < 3; r++) begin
            read_reg(2'(r), v);
            check(v == '0, "R11 reset register", 64'(v), 64'd0);
        end
    endtask

    task automatic t_burst;
        logic [RW-1:0] v;
        cfg_write(2'd0, 32'h0100);
        cfg_write(2'd1, 32'd4);
        read_reg(2'd0, v);
        check(v == 32'h0100, "R11 address readback", 64'(v), 64'h100);
        cfg_write(2'd2, 32'h1);
        bus_busy = 1'b1;
        #1;
        check(bus_req == 1'b1, "R1 request after go", 64'(bus_req), 64'd1);
        check(mem_we == 1'b0, "R1 no write before grant", 64'(mem_we), 64'd0);
        xfer_run(16'h0100, 4, 1'b0, 32'hFFFF_FFFC, 32'hFFFF_FFFF, "burst");
        clear_irq("burst");
    endtask

    task automatic t_steal;
        cfg_write(2'd0, 32'h0200);
        cfg_write(2'd1, 32'd3);
        cfg_write(2'd2, 32'h3);
        xfer_run(16'h0200, 3, 1'b1, 32'hFFFF_FFFF, 32'h0000_004D, "steal");
        clear_irq("steal");
    endtask

    task automatic t_go_while_active;
        logic [RW-1:0] v;
        cfg_write(2'd0, 32'h0300);
        cfg_write(2'd1, 32'd5);
        cfg_write(2'd2, 32'h1);
        cfg_write(2'd0, 32'h0700);
        cfg_write(2'd2, 32'h3);
        read_reg(2'd2, v);
        check(v[2:0] == 3'b101, "R8 error set, still active", 64'(v[2:0]), 64'b101);
        xfer_run(16'h0300, 5, 1'b0, 32'hFFFF_FFF6, 32'h0000_0000, "R8 go-while-active");
        read_reg(2'd2, v);
        check(v[2] == 1'b1, "R8 error sticky", 64'(v[2]), 64'd1);
        cfg_write(2'd2, 32'hC);
        read_reg(2'd2, v);
        check(v[2:0] == 3'b000, "R8 error cleared", 64'(v[2:0]), 64'd0);
    endtask

    task automatic t_zero_count;
        cfg_write(2'd1, 32'd0);
        cfg_write(2'd2, 32'h1);
        #1;
        check(bus_req == 1'b0, "R9 no request for zero count", 64'(bus_req), 64'd0);
        check(irq == 1'b1, "R9 irq for zero count", 64'(irq), 64'd1);
        cfg_write(2'd2, 32'h4);
    endtask

    task automatic t_saturate;
        logic [RW-1:0] v;
        cfg_write(2'd1, 32'd100);
        read_reg(2'd1, v);
        check(v == 32'(DEPTH), "R10 count saturation", 64'(v), 64'(DEPTH));
        cfg_write(2'd1, 32'd16);
        read_reg(2'd1, v);
        check(v == 32'd16, "R10 count at depth", 64'(v), 64'd16);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        for (int w = 0; w < DEPTH; w++) begin
            exp_buf[w] = 32'hC0DE_0000 ^ (32'(w) * 32'h0101_0101);
            @(negedge clk);
            buf_we = 1'b1; buf_idx = IW'(w); buf_wdata = exp_buf[w];
        end
        @(negedge clk);
        buf_we = 1'b0;
        t_burst();
        t_steal();
        t_go_while_active();
        t_zero_count();
        t_saturate();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule